// File: doc/BRIEF.md
# Video RAM Access Slot Arbiter

This block decides, pixel clock by pixel clock, who may use the video RAM in a tile-based display processor. A line counter runs over the 342 pixel clocks of a scanline and cuts it into access slots of four pixel clocks each. Each slot goes either to the renderer's own fetches (name table, pattern, sprite) or to the external CPU port. The renderer fetches 16-bit words. The CPU side has no first-come arbitration. Instead it follows a fixed schedule tied to the pixel position. That schedule is sparse while a visible line is being drawn, and every slot is open to the CPU during vertical blank or when the display is switched off.

CPU writes go into a one-entry holding register. A busy flag stays high from the cycle the write is taken until the next external slot commits it to memory. While busy is high, a new request is not taken. The CPU keeps it asserted, and the request is accepted once the buffer empties. With this schedule, a CPU that spaces its writes 26 CPU clocks apart (39 pixel clocks) always finds the buffer free.

Top module: `vram_slot_arb`

## Requirements
- R1: The line is 342 clock cycles long. `line_start_o` is high only in the first cycle of every line, and the counter wraps from 341 to 0.
- R2: `slot_strobe_o` is high in each cycle whose line position is a multiple of 4 and below 340, which gives 85 slots per line. The two cycles at positions 340 and 341 form an idle partial slot with no strobe and type idle (code 0).
- R3: On an active line (`display_en_i` high, `vblank_i` low) exactly 11 slots are external (type code 1). These are the slots with index below 64 whose index modulo 8 equals 3, plus slots 68, 76 and 84. `ext_slot_o` marks their strobe cycle.
- R4: On active lines, the distance from one external strobe to the next never exceeds 39 clock cycles, and this holds across the line boundary too. The worst case is 36.
- R5: With `vblank_i` high, all 85 full slots are external.
- R6: With `display_en_i` low, all 85 full slots are external, whatever `vblank_i` is.
- R7: On active lines, the non-external slots are typed by their index. Slots below 64 are typed by index modulo 8: 0 is name fetch (code 2); 1, 2, 4 and 5 are pattern fetch (code 3); 6 and 7 are sprite fetch (code 4). Non-external slots 64 to 84 are sprite fetches. `ren_grant_o` is high on the strobe of each renderer slot.
- R8: When `cpu_wr_i` is high and `cpu_busy_o` is low at a clock edge, the address and data are captured and `cpu_busy_o` is high after that edge.
- R9: A held write is committed at the first external strobe after it was taken. The edge that ends that strobe cycle raises `mem_we_o` and `cpu_ack_o` for one cycle, carrying the captured address and data, and clears `cpu_busy_o` at the same time.
- R10: A request made while `cpu_busy_o` is high is not captured. It does not alter the held write, and it is taken on the first edge after busy clears, provided it is still held.
- R11: During reset `cpu_busy_o`, `mem_we_o` and `cpu_ack_o` are low and the line position is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| display_en_i | input | 1 | Display on; low opens every slot to the CPU |
| vblank_i | input | 1 | Current line lies outside the active area |
| cpu_wr_i | input | 1 | CPU write request, held until taken |
| cpu_addr_i | input | 14 | CPU byte address |
| cpu_data_i | input | 8 | CPU write data |
| cpu_busy_o | output | 1 | Holding register occupied |
| cpu_ack_o | output | 1 | One-cycle pulse when the held write commits |
| line_start_o | output | 1 | First cycle of a line |
| slot_strobe_o | output | 1 | First cycle of a full slot |
| slot_type_o | output | 3 | Slot owner: 0 idle, 1 external, 2 name, 3 pattern, 4 sprite |
| ext_slot_o | output | 1 | Strobe of an external slot |
| ren_grant_o | output | 1 | Strobe of a renderer slot |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | 14 | Memory write address |
| mem_wdata_o | output | 8 | Memory write data |

## Verification
The assertions rely on the CPU holding `cpu_wr_i` until it sees busy go high or its write get acknowledged. They also rely on the two mode inputs being level signals that the slot decoder reads directly. Mid-line mode changes are therefore legal for the gap check, because the active schedule never leaves more than 36 cycles between external slots. The stimulus changes the mode inputs only on falling edges and just before it waits for a line start. Each write request is held until the bench observes busy. The second write is deliberately left asserted through the commit of the first.

// File: rtl/vram_slot_pkg.sv
package vram_slot_pkg;
  typedef enum logic [2:0] {
    SLOT_IDLE = 3'd0,
    SLOT_EXT  = 3'd1,
    SLOT_NAME = 3'd2,
    SLOT_PAT  = 3'd3,
    SLOT_SPR  = 3'd4
  } slot_kind_e;
endpackage

// File: rtl/vslot_line_ctr.sv
module vslot_line_ctr #(
  parameter int LINE_PIXELS = 342,
  localparam int PIX_W = $clog2(LINE_PIXELS)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  output logic [PIX_W-1:0] pix_o,
  output logic             line_start_o
);
  localparam logic [PIX_W-1:0] LAST_PIX = PIX_W'(LINE_PIXELS - 1);

  logic [PIX_W-1:0] pix_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               pix_q <= '0;
    else if (pix_q == LAST_PIX) pix_q <= '0;
    else                       pix_q <= pix_q + 1'b1;
  end

  assign pix_o        = pix_q;
  assign line_start_o = (pix_q == '0);

  assert_pix_wrap_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pix_q == LAST_PIX) |=> (pix_q == '0));
  assert_pix_range_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pix_q <= LAST_PIX);
endmodule

// File: rtl/vslot_decode.sv
module vslot_decode
  import vram_slot_pkg::*;
#(
  parameter int LINE_PIXELS  = 342,
  parameter int SLOT_PIX     = 4,
  parameter int ACTIVE_SLOTS = 64,
  parameter int GROUP_SLOTS  = 8,
  parameter int EXT_PHASE    = 3,
  parameter int HB_EXT_FIRST = 68,
  parameter int HB_EXT_STEP  = 8,
  localparam int PIX_W      = $clog2(LINE_PIXELS),
  localparam int FULL_SLOTS = LINE_PIXELS / SLOT_PIX
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [PIX_W-1:0] pix_i,
  input  logic             active_i,
  output logic             strobe_o,
  output slot_kind_e       type_o
);
  int unsigned pix_u, slot_u, phase_u, grp_u;
  logic        full;

  always_comb begin
    pix_u   = 32'(pix_i);
    slot_u  = pix_u / SLOT_PIX;
    phase_u = pix_u % SLOT_PIX;
    grp_u   = slot_u % GROUP_SLOTS;
    full    = (slot_u < FULL_SLOTS);
    strobe_o = full && (phase_u == 0);
    if (!full)
      type_o = SLOT_IDLE;
    else if (!active_i)
      type_o = SLOT_EXT;
    else if (slot_u < ACTIVE_SLOTS) begin
      if (grp_u == EXT_PHASE)              type_o = SLOT_EXT;
      else if (grp_u == 0)                 type_o = SLOT_NAME;
      else if (grp_u >= GROUP_SLOTS - 2)   type_o = SLOT_SPR;
      else                                 type_o = SLOT_PAT;
    end else if (slot_u >= HB_EXT_FIRST &&
                 ((slot_u - HB_EXT_FIRST) % HB_EXT_STEP) == 0)
      type_o = SLOT_EXT;
    else
      type_o = SLOT_SPR;
  end

  assert_partial_idle_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (32'(pix_i) >= FULL_SLOTS * SLOT_PIX) |-> (!strobe_o && type_o == SLOT_IDLE));
  assert_blank_all_ext_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!active_i && strobe_o) |-> (type_o == SLOT_EXT));
endmodule

// File: rtl/vslot_wr_buf.sv
module vslot_wr_buf #(
  parameter int ADDR_W = 14,
  parameter int DATA_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              ext_i,
  input  logic              wr_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [DATA_W-1:0] data_i,
  output logic              busy_o,
  output logic              ack_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic              pend_q, we_q;
  logic [ADDR_W-1:0] addr_q, maddr_q;
  logic [DATA_W-1:0] data_q, mdata_q;
  logic              accept, commit;

  assign accept = wr_i && !pend_q;
  assign commit = pend_q && ext_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q  <= 1'b0;
      we_q    <= 1'b0;
      addr_q  <= '0;
      data_q  <= '0;
      maddr_q <= '0;
      mdata_q <= '0;
    end else begin
      we_q <= commit;
      if (accept) begin
        pend_q <= 1'b1;
        addr_q <= addr_i;
        data_q <= data_i;
      end else if (commit) begin
        pend_q  <= 1'b0;
        maddr_q <= addr_q;
        mdata_q <= data_q;
      end
    end
  end

  assign busy_o      = pend_q;
  assign ack_o       = we_q;
  assign mem_we_o    = we_q;
  assign mem_addr_o  = maddr_q;
  assign mem_wdata_o = mdata_q;

  assert_accept_busy_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_i && !busy_o) |=> busy_o);
  assert_hold_to_slot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && !ext_i) |=> (busy_o && !mem_we_o));
  assert_commit_at_slot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && ext_i) |=> (mem_we_o && !busy_o));
  assert_stall_keeps_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_o |=> ($stable(addr_q) && $stable(data_q)));
endmodule

// File: rtl/vram_slot_arb.sv
module vram_slot_arb
  import vram_slot_pkg::*;
#(
  parameter int LINE_PIXELS = 342,
  parameter int SLOT_PIX    = 4,
  parameter int ADDR_W      = 14,
  parameter int DATA_W      = 8,
  parameter int MAX_GAP     = 39,
  localparam int PIX_W = $clog2(LINE_PIXELS),
  localparam int GAP_W = $clog2(LINE_PIXELS + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              display_en_i,
  input  logic              vblank_i,
  input  logic              cpu_wr_i,
  input  logic [ADDR_W-1:0] cpu_addr_i,
  input  logic [DATA_W-1:0] cpu_data_i,
  output logic              cpu_busy_o,
  output logic              cpu_ack_o,
  output logic              line_start_o,
  output logic              slot_strobe_o,
  output logic [2:0]        slot_type_o,
  output logic              ext_slot_o,
  output logic              ren_grant_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [DATA_W-1:0] mem_wdata_o
);
  logic [PIX_W-1:0] pix;
  logic             strobe;
  slot_kind_e       kind;
  logic             active;

  assign active = display_en_i && !vblank_i;

  vslot_line_ctr #(.LINE_PIXELS(LINE_PIXELS)) u_ctr (
    .clk_i(clk_i), .rst_ni(rst_ni), .pix_o(pix), .line_start_o(line_start_o));

  vslot_decode #(.LINE_PIXELS(LINE_PIXELS), .SLOT_PIX(SLOT_PIX)) u_dec (
    .clk_i(clk_i), .rst_ni(rst_ni), .pix_i(pix), .active_i(active),
    .strobe_o(strobe), .type_o(kind));

  assign slot_strobe_o = strobe;
  assign slot_type_o   = kind;
  assign ext_slot_o    = strobe && (kind == SLOT_EXT);
  assign ren_grant_o   = strobe && (kind != SLOT_EXT) && (kind != SLOT_IDLE);

  vslot_wr_buf #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
    .clk_i(clk_i), .rst_ni(rst_ni), .ext_i(ext_slot_o),
    .wr_i(cpu_wr_i), .addr_i(cpu_addr_i), .data_i(cpu_data_i),
    .busy_o(cpu_busy_o), .ack_o(cpu_ack_o), .mem_we_o(mem_we_o),
    .mem_addr_o(mem_addr_o), .mem_wdata_o(mem_wdata_o));

  // cycles since the previous external strobe, saturating
  logic [GAP_W-1:0] gap_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                         gap_q <= '0;
    else if (ext_slot_o)                 gap_q <= GAP_W'(1);
    else if (gap_q != GAP_W'(LINE_PIXELS)) gap_q <= gap_q + 1'b1;
  end

  assert_ext_gap_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_slot_o |-> (32'(gap_q) <= MAX_GAP));
  assert_grant_excl_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(ext_slot_o && ren_grant_o));
endmodule

// File: tb/vram_slot_arb_tb_top.sv
module vram_slot_arb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int LINE = 342;
  localparam int WDOG = 150000;

  typedef struct packed {
    logic        vb;
    logic        en;
    logic [31:0] n_ext;
    logic [31:0] max_gap;
  } row_t;

  localparam row_t ROWS [4] = '{
    '{vb: 1'b0, en: 1'b1, n_ext: 32'd11, max_gap: 32'd36},
    '{vb: 1'b1, en: 1'b1, n_ext: 32'd85, max_gap: 32'd6},
    '{vb: 1'b0, en: 1'b0, n_ext: 32'd85, max_gap: 32'd6},
    '{vb: 1'b1, en: 1'b0, n_ext: 32'd85, max_gap: 32'd6}
  };

  logic clk_i = 1'b0, rst_ni = 1'b0;
  logic display_en_i = 1'b1, vblank_i = 1'b0, cpu_wr_i = 1'b0;
  logic [13:0] cpu_addr_i = '0;
  logic [7:0]  cpu_data_i = '0;
  logic cpu_busy_o, cpu_ack_o, line_start_o, slot_strobe_o, ext_slot_o, ren_grant_o, mem_we_o;
  logic [2:0]  slot_type_o;
  logic [13:0] mem_addr_o;
  logic [7:0]  mem_wdata_o;

  int n_chk = 0, n_err = 0, cyc = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  vram_slot_arb dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  always @(posedge clk_i) begin
    cyc++;
    if (cyc == WDOG) begin
      chk(1'b0, "watchdog", cyc, WDOG);
      $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  function automatic int exp_type(input int slot, input bit act);
    if (slot >= 85) return 0;
    if (!act) return 1;
    if (slot < 64) begin
      case (slot % 8)
        3: return 1;
        0: return 2;
        6, 7: return 4;
        default: return 3;
      endcase
    end
    if (slot == 68 || slot == 76 || slot == 84) return 1;
    return 4;
  endfunction

  task automatic wait_line();
    do @(negedge clk_i); while (!line_start_o);
  endtask

  task automatic run_row(input row_t r);
    int ext_n = 0, strb_n = 0, gap_max = 0, last = -1;
    int bad_ls = 0, bad_strb = 0, bad_type = 0, bad_grant = 0;
    bit act;
    string ext_req;
    act = r.en && !r.vb;
    ext_req = act ? "R3" : (!r.en ? "R6" : "R5");
    vblank_i = r.vb;
    display_en_i = r.en;
    wait_line();
    for (int t = 0; t < 2 * LINE; t++) begin
      int pos;
      if (t > 0) @(negedge clk_i);
      pos = t % LINE;
      if (line_start_o != (pos == 0)) bad_ls++;
      if (slot_strobe_o != ((pos % 4 == 0) && pos < 340)) bad_strb++;
      if (slot_strobe_o) begin
        strb_n++;
        if (32'(slot_type_o) != exp_type(pos / 4, act)) bad_type++;
        if (ren_grant_o != (exp_type(pos / 4, act) > 1)) bad_grant++;
      end else if (pos >= 340 && slot_type_o != 3'd0) bad_type++;
      if (ext_slot_o) begin
        ext_n++;
        if (last >= 0 && t - last > gap_max) gap_max = t - last;
        last = t;
      end
    end
    chk(bad_ls == 0, "R1 line start", bad_ls, 0);
    chk(bad_strb == 0 && strb_n == 170, "R2 strobes", strb_n, 170);
    chk(ext_n == 2 * int'(r.n_ext), ext_req, ext_n, 2 * int'(r.n_ext));
    chk(gap_max == int'(r.max_gap), act ? "R4 gap" : "R5/R6 gap", gap_max, int'(r.max_gap));
    chk(bad_type == 0, "R7 types", bad_type, 0);
    chk(bad_grant == 0, "R7 grant", bad_grant, 0);
  endtask

  // waits for the first external strobe, then expects the commit pulse one cycle later
  task automatic wait_commit(input logic [13:0] a, input logic [7:0] d, input string req);
    bit seen = 0;
    bit early = 0;
    for (int i = 0; i < 2 * LINE; i++) begin
      @(negedge clk_i);
      if (seen) begin
        chk(mem_we_o && cpu_ack_o && !cpu_busy_o, req, int'(mem_we_o), 1);
        chk(mem_addr_o == a && mem_wdata_o == d, req, int'(mem_wdata_o), int'(d));
        chk(!early, "R9 no early commit", int'(early), 0);
        return;
      end
      if (mem_we_o) early = 1;
      if (ext_slot_o) seen = 1;
    end
    chk(1'b0, req, 0, 1);
  endtask

  initial begin
    #(CLK_PERIOD * 3);
    chk(!cpu_busy_o && !mem_we_o && !cpu_ack_o && line_start_o, "R11 reset",
        int'(cpu_busy_o) + int'(mem_we_o), 0);
    @(negedge clk_i);
    rst_ni = 1'b1;

    foreach (ROWS[i]) run_row(ROWS[i]);

    // single write on an active line
    vblank_i = 1'b0;
    display_en_i = 1'b1;
    wait_line();
    repeat (20) @(negedge clk_i);
    cpu_wr_i = 1'b1; cpu_addr_i = 14'h1234; cpu_data_i = 8'h5a;
    @(negedge clk_i);
    cpu_wr_i = 1'b0;
    chk(cpu_busy_o, "R8 busy after request", int'(cpu_busy_o), 1);
    wait_commit(14'h1234, 8'h5a, "R9 commit");

    // second request during busy is stalled, then taken
    wait_line();
    repeat (70) @(negedge clk_i);
    cpu_wr_i = 1'b1; cpu_addr_i = 14'h0abc; cpu_data_i = 8'h11;
    @(negedge clk_i);
    cpu_addr_i = 14'h2def; cpu_data_i = 8'hc3;
    wait_commit(14'h0abc, 8'h11, "R10 first kept");
    @(negedge clk_i);
    chk(cpu_busy_o, "R10 stalled taken", int'(cpu_busy_o), 1);
    cpu_wr_i = 1'b0;
    wait_commit(14'h2def, 8'hc3, "R10 second");
    begin
      int extra = 0;
      for (int i = 0; i < LINE; i++) begin
        @(negedge clk_i);
        if (mem_we_o || cpu_busy_o) extra++;
      end
      chk(extra == 0, "R10 no repeat", extra, 0);
    end

    // write during blanking commits on the very next slot
    vblank_i = 1'b1;
    wait_line();
    repeat (2) @(negedge clk_i);
    cpu_wr_i = 1'b1; cpu_addr_i = 14'h3001; cpu_data_i = 8'h77;
    @(negedge clk_i);
    cpu_wr_i = 1'b0;
    chk(cpu_busy_o, "R8 busy blank", int'(cpu_busy_o), 1);
    wait_commit(14'h3001, 8'h77, "R5 blank commit");

    $display("CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule